// File: doc/BRIEF.md
# Serial Command Word Receiver

This block accepts command words over a three-wire serial port made of a serial clock, a serial data line and an active-low select/load line. Bits are captured into a 32-stage shift path while the select/load line is low. When that line returns high, the last 24 bits captured are split into a 4-bit command, a 4-bit channel address and a 16-bit data word. These fields are handed to a downstream register bank, together with a strobe that lasts one system clock. The block does not decode the command and holds no channel state.

All three serial inputs are sampled by a faster system clock through two-flop synchronizers, and the serial edges are found in the synchronized samples. The tail of the shift path drives a serial output on falling serial clock edges, so several receivers can be chained. A 24-bit frame and a 32-bit frame decode the same way, because the extra leading byte of a 32-bit frame shifts out past the decoded window.

Top module: `ser_cmd_rx`

## Requirements
- R1: After reset `exec_o`, `cmd_o`, `addr_o`, `data_o` and `sdo_o` are all 0.
- R2: A bit is taken from `sdi_i` only on a rising edge of `sclk_i` while `ld_ni` is low. Serial clock edges while `ld_ni` is high leave the shift path and `sdo_o` unchanged.
- R3: For a 24-bit frame, the first 4 bits sent become `cmd_o`, the next 4 become `addr_o` and the last 16 become `data_o`, each field sent MSB first. The fields are presented with a strobe when `ld_ni` rises.
- R4: When a frame has more than 24 bits, for example 32 with 8 leading don't-care bits, the fields come from the last 24 bits shifted in.
- R5: A frame with fewer than 24 rising serial clock edges gives no strobe and leaves the field outputs unchanged. Exactly 24 edges are enough.
- R6: `exec_o` is high for exactly one system clock per qualifying frame. The field outputs change only in the cycle in which `exec_o` is high.
- R7: A bit taken on rising serial edge k appears on `sdo_o` after the falling serial edge that follows rising edge k+31. Stages that have never been written read as 0. `sdo_o` changes only after a falling serial edge and holds its value while `ld_ni` is high.
- R8: `exec_o` goes high on the third rising system clock edge after `ld_ni` rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| ld_ni | input | 1 | Active-low select; its rising edge loads the frame |
| sdo_o | output | 1 | Chained serial data out (shift path tail) |
| exec_o | output | 1 | One-cycle execute strobe |
| cmd_o | output | 4 | Command field |
| addr_o | output | 4 | Channel address field |
| data_o | output | 16 | Data field |

## Verification
The assertions assume that every level of `sclk_i` and `ld_ni` lasts at least two system clocks. They also assume that `sdi_i` is stable around each rising serial edge and that `ld_ni` does not change in the same system cycle as `sclk_i`. If any of these is violated, the synchronized samples can merge or reorder edges. The stimulus changes one serial input at a time, on the falling system clock edge. Each serial clock half-period lasts four system clocks, and `ld_ni` gets four system clocks of margin on each side of a frame.

// File: rtl/ser_cmd_pkg.sv
package ser_cmd_pkg;
  localparam int SR_W     = 32;
  localparam int CMD_W    = 4;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;
  localparam int MIN_BITS = CMD_W + ADDR_W + DATA_W;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/ser_cmd_sync.sv
module ser_cmd_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1 <= RST_VAL[g];
        ff2 <= RST_VAL[g];
      end else begin
        ff1 <= d_i[g];
        ff2 <= ff1;
      end
    end
    assign q_o[g] = ff2;
  end
endmodule

// File: rtl/ser_cmd_edges.sv
module ser_cmd_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_s_i,
  input  logic ld_s_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic ld_rise_o
);
  logic sclk_q, ld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      ld_q   <= 1'b1;
    end else begin
      sclk_q <= sclk_s_i;
      ld_q   <= ld_s_i;
    end
  end

  assign sclk_rise_o = sclk_s_i & ~sclk_q;
  assign sclk_fall_o = ~sclk_s_i & sclk_q;
  assign ld_rise_o   = ld_s_i & ~ld_q;
endmodule

// File: rtl/ser_cmd_shreg.sv
module ser_cmd_shreg #(
  parameter int SR_W     = 32,
  parameter int MIN_BITS = 24,
  localparam int CNT_W   = $clog2(MIN_BITS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_s_i,
  input  logic             rise_i,
  input  logic             fall_i,
  input  logic             bit_i,
  output logic [SR_W-1:0]  sr_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             sdo_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_BITS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_o  <= '0;
      cnt_o <= '0;
      sdo_o <= 1'b0;
    end else begin
      if (!ld_s_i && rise_i) sr_o <= {sr_o[SR_W-2:0], bit_i};
      // count clears while deselected; saturates once a full word is in
      if (ld_s_i)                          cnt_o <= '0;
      else if (rise_i && cnt_o != CNT_MAX) cnt_o <= cnt_o + 1'b1;
      if (fall_i) sdo_o <= sr_o[SR_W-1];
    end
  end
endmodule

// File: rtl/ser_cmd_capture.sv
module ser_cmd_capture
  import ser_cmd_pkg::*;
#(
  parameter int MIN_BITS = 24,
  localparam int CNT_W   = $clog2(MIN_BITS + 1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ld_rise_i,
  input  logic [CNT_W-1:0]    cnt_i,
  input  logic [MIN_BITS-1:0] word_i,
  output logic                exec_o,
  output cmd_word_t           word_o
);
  logic fire;
  assign fire = ld_rise_i && (cnt_i >= CNT_W'(MIN_BITS));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exec_o <= 1'b0;
      word_o <= '0;
    end else begin
      exec_o <= fire;
      if (fire) word_o <= cmd_word_t'(word_i);
    end
  end
endmodule

// File: rtl/ser_cmd_rx.sv
module ser_cmd_rx
  import ser_cmd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              ld_ni,
  output logic              sdo_o,
  output logic              exec_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int CNT_W = $clog2(MIN_BITS + 1);

  logic [2:0]       sync_q;
  logic             sclk_s, sdi_s, ld_s;
  logic             sclk_rise, sclk_fall, ld_rise;
  logic [SR_W-1:0]  shreg;
  logic [CNT_W-1:0] bit_cnt;
  cmd_word_t        word;

  ser_cmd_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ld_ni, sdi_i, sclk_i}),
    .q_o   (sync_q)
  );
  assign {ld_s, sdi_s, sclk_s} = sync_q;

  ser_cmd_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_s_i   (sclk_s),
    .ld_s_i     (ld_s),
    .sclk_rise_o(sclk_rise),
    .sclk_fall_o(sclk_fall),
    .ld_rise_o  (ld_rise)
  );

  ser_cmd_shreg #(.SR_W(SR_W), .MIN_BITS(MIN_BITS)) u_shreg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ld_s_i(ld_s),
    .rise_i(sclk_rise),
    .fall_i(sclk_fall),
    .bit_i (sdi_s),
    .sr_o  (shreg),
    .cnt_o (bit_cnt),
    .sdo_o (sdo_o)
  );

  ser_cmd_capture #(.MIN_BITS(MIN_BITS)) u_cap (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_rise_i(ld_rise),
    .cnt_i    (bit_cnt),
    .word_i   (shreg[MIN_BITS-1:0]),
    .exec_o   (exec_o),
    .word_o   (word)
  );

  assign cmd_o  = word.cmd;
  assign addr_o = word.addr;
  assign data_o = word.data;
endmodule

// File: rtl/ser_cmd_rx_chk.sv
module ser_cmd_rx_chk
  import ser_cmd_pkg::*;
#(
  localparam int CNT_W = $clog2(MIN_BITS + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_s,
  input logic             sclk_fall,
  input logic             ld_rise,
  input logic [CNT_W-1:0] bit_cnt,
  input logic [SR_W-1:0]  shreg,
  input logic             sdo_o,
  input logic             exec_o,
  input cmd_word_t        word
);
  AST_NO_SHIFT_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_s |=> $stable(shreg)); // R2
  AST_STROBE_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> $past(ld_rise)); // R3
  AST_SHORT_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> ($past(bit_cnt) >= CNT_W'(MIN_BITS))); // R5
  AST_STROBE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |=> !exec_o); // R6
  AST_FIELDS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_o |-> $stable(word)); // R6
  AST_SDO_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sdo_o) |-> $past(sclk_fall)); // R7
endmodule

bind ser_cmd_rx ser_cmd_rx_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ld_s     (ld_s),
  .sclk_fall(sclk_fall),
  .ld_rise  (ld_rise),
  .bit_cnt  (bit_cnt),
  .shreg    (shreg),
  .sdo_o    (sdo_o),
  .exec_o   (exec_o),
  .word     (word)
);

// File: tb/ser_cmd_rx_bench.sv
module ser_cmd_rx_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, sdi = 1'b0, ld_n = 1'b1;
  logic sdo, exec;
  logic [3:0] cmd, addr;
  logic [15:0] data;

  int total = 0, bad = 0, cyc = 0, strobes = 0, exec_cyc = 0;
  bit done = 0;
  logic [3:0] got_cmd = '0, got_addr = '0;
  logic [15:0] got_data = '0;

  always #10 clk = ~clk;

  ser_cmd_rx u_ser_cmd_rx (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .sdi_i(sdi), .ld_ni(ld_n),
    .sdo_o(sdo), .exec_o(exec), .cmd_o(cmd), .addr_o(addr), .data_o(data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // behavioural reference: inputs seen two clocks late, bit history in a queue
  bit q[$];
  int m_cnt = 0;
  logic [2:0] d1 = 3'b100, d2 = 3'b100, d3 = 3'b100; // {ld, sdi, sclk}
  logic m_exec = 0, m_sdo = 0;
  logic [23:0] m_word = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      q.delete(); m_cnt = 0; m_exec = 0; m_sdo = 0; m_word = '0;
      d1 = 3'b100; d2 = 3'b100; d3 = 3'b100;
    end else begin
      m_exec = 0;
      if (!d3[2] && d2[2]) begin
        if (m_cnt >= 24) begin
          m_exec = 1;
          for (int i = 0; i < 24; i++) m_word[23-i] = q[q.size()-24+i];
        end
      end
      if (d3[0] && !d2[0]) m_sdo = (q.size() == 32) ? q[0] : 1'b0;
      if (!d3[0] && d2[0] && !d2[2]) begin
        q.push_back(d2[1]);
        if (q.size() > 32) void'(q.pop_front());
        m_cnt++;
      end
      if (d2[2]) m_cnt = 0;
      d3 = d2; d2 = d1; d1 = {ld_n, sdi, sclk};
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(exec === m_exec, "R6 model strobe", exec, m_exec);
      chk({cmd, addr, data} === m_word, "R3 model fields", {cmd, addr, data}, m_word);
      chk(sdo === m_sdo, "R7 model sdo", sdo, m_sdo);
      if (exec) begin
        strobes++; exec_cyc = cyc;
        got_cmd = cmd; got_addr = addr; got_data = data;
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  int ld_rise_cyc = 0;
  task automatic send(input logic [31:0] w, input int n);
    ld_n = 1'b0; wait_clk(4);
    for (int i = n - 1; i >= 0; i--) begin
      sdi = w[i]; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4);
    ld_n = 1'b1; ld_rise_cyc = cyc;
    wait_clk(8);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int s0;
    wait_clk(3);
    chk(exec === 1'b0, "R1 exec reset", exec, 0);
    chk({cmd, addr, data} === 24'h0, "R1 fields reset", {cmd, addr, data}, 0);
    chk(sdo === 1'b0, "R1 sdo reset", sdo, 0);
    rst_n = 1'b1; wait_clk(4);

    // R3: 24-bit frame
    s0 = strobes;
    send(32'h003A1234, 24);
    chk(strobes == s0 + 1, "R3 strobe count", strobes, s0 + 1);
    chk(got_cmd == 4'h3, "R3 cmd", got_cmd, 3);
    chk(got_addr == 4'hA, "R3 addr", got_addr, 4'hA);
    chk(got_data == 16'h1234, "R3 data", got_data, 16'h1234);
    chk(exec_cyc - ld_rise_cyc == 3, "R8 strobe latency", exec_cyc - ld_rise_cyc, 3);

    // R4: 32-bit frame, leading byte ignored
    send(32'hA57EC0DE, 32);
    chk({got_cmd, got_addr, got_data} == 24'h7EC0DE, "R4 fields",
        {got_cmd, got_addr, got_data}, 24'h7EC0DE);
    chk(sdo === 1'b1, "R7 sdo first bit of frame", sdo, 1);
    send(32'h0F00FFFF, 32);
    chk(sdo === 1'b0, "R7 sdo first bit of second frame", sdo, 0);

    // R2: serial clock edges while deselected are ignored
    for (int i = 0; i < 6; i++) begin
      sdi = 1'b1; wait_clk(4); sclk = 1'b1; wait_clk(4); sclk = 1'b0;
    end
    wait_clk(6);
    chk(sdo === 1'b0, "R2 sdo held while deselected", sdo, 0);
    chk(strobes == 3, "R2 no strobe while deselected", strobes, 3);

    // R5: short frames
    s0 = strobes;
    send(32'h00012345, 20);
    chk(strobes == s0, "R5 20-bit frame no strobe", strobes, s0);
    send(32'h00876543, 23);
    chk(strobes == s0, "R5 23-bit frame no strobe", strobes, s0);
    chk({cmd, addr, data} == 24'h0FFFF0 || {cmd, addr, data} == 24'h00FFFF,
        "R5 fields unchanged", {cmd, addr, data}, 24'h00FFFF);
    send(32'h00C50001, 24);
    chk(strobes == s0 + 1, "R5 24-bit boundary strobe", strobes, s0 + 1);
    chk({got_cmd, got_addr, got_data} == 24'hC50001, "R5 boundary fields",
        {got_cmd, got_addr, got_data}, 24'hC50001);

    // R6: strobe lasts one cycle (counted per cycle high)
    s0 = strobes;
    send(32'hFFFFFFFF, 32);
    chk(strobes == s0 + 1, "R6 single-cycle strobe", strobes, s0 + 1);
    chk({got_cmd, got_addr, got_data} == 24'hFFFFFF, "R4 all-ones frame",
        {got_cmd, got_addr, got_data}, 24'hFFFFFF);

    wait_clk(4);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule